// File: doc/BRIEF.md
# Vectored Interrupt Controller, Two Banks

This block collects up to 64 interrupt inputs and presents them to a processor as two request lines: a normal request and a fast request. Every source has a route choice (normal or fast), an enable, a choice between edge and level detection, and an input polarity. Each of these is a bit of a 32-bit bank register, and the block has one bank for every 32 sources. Software uses a small 32-bit register bus. It writes the per-source controls and reads the raw, normal and fast status words. It can force sources pending from software.

To service an interrupt, software reads a vector register. The read returns the number of the most urgent pending source and also records that source as the one in service. While a source is in service, only sources with a lower number can raise the same request line again. Any write to the end-of-service register for that route releases it. A master enable bit gates each request line.

Reads return combinationally the register at `bus_addr`. Writes take effect at the clock edge where `bus_wr` is high. A vector read counts as an acknowledge only at a clock edge where `bus_rd` is high.

Top module: `vic_dual_bank`

## Requirements
- R1: Source n belongs to bank n/32 at bit n%32. The register for bank b of any per-source group sits at the group's base offset plus 4*b. Writes and reads to a bank number at or above NUM_BANKS have no effect and read zero.
- R2: Writing 1 to a bit at 0x30+4b sets that source's enable. Writing 1 at 0x20+4b clears it. Bits written as 0 keep their value. 0x10+4b reads the enables, and writes there are ignored.
- R3: Route select at 0x00+4b: 1 sends the source to the fast route, 0 to the normal route. 0x80+4b reads the enabled pending sources on the normal route, and 0x90+4b reads those on the fast route.
- R4: Polarity at 0x50+4b: 1 inverts the input (active-low or falling edge). 0x A0+4b reads the inputs after polarity and before any masking. A source with a 0 in the type register (0x40+4b) is pending while its adjusted input is 1.
- R5: A source with a 1 in the type register latches pending on a 0-to-1 change of its adjusted input. It stays pending after the input returns to 0, until software writes 1 to its bit at 0xB0+4b. If a clear and a new edge fall in the same cycle, the source stays pending. A clear while the input is held high, with no new edge, leaves it clear.
- R6: 0xC0+4b is a read/write software word. Each 1 makes its source pending, ORed with the hardware condition.
- R7: Register 0x68 bit 0 gates `irq_o` and bit 1 gates `fiq_o`. The gates leave the status words unchanged.
- R8: 0xD0 and 0xD4 read the lowest-numbered eligible source on the normal route, and 0xDC and 0xE0 do the same for the fast route. Both return 64 when no source is eligible. A request output is high when its master bit is 1 and its vector is not 64.
- R9: A vector read with `bus_rd` high and a vector below 64 stores that number as in service: 0xE8 for the normal route, 0xF0 for the fast route. From then on, only sources numbered below it are eligible on that route. The in-service value is 64 when idle.
- R10: Any write to 0xD8 ends normal-route service, and any write to 0xE4 ends fast-route service. The in-service value returns to 64.
- R11: After reset, all control, latch, software and master bits are 0, both outputs are low and both in-service values are 64. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32*NUM_BANKS | Interrupt source inputs |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (acknowledges on vector reads) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle, the assertions check the following. Enable-set and enable-clear writes land on exactly the bits written. A detected edge on an edge-type source always latches, even against a simultaneous clear. An end-of-service write always returns the route to idle. An acknowledge records the vector that was presented. The fast output never rises while its master bit is off. Only the bench scenarios can show the rest: the per-source mapping across all 64 sources, lowest-number priority across many pairs, polarity and route selection, and masking by the in-service level, including preemption by a lower-numbered source.

// File: rtl/vic_dual_bank.sv
module vic_dual_bank #(
  parameter int NUM_BANKS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [32*NUM_BANKS-1:0] src_i,
  input  logic [7:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    irq_o,
  output logic                    fiq_o
);
  localparam int NSRC = 32 * NUM_BANKS;
  localparam int VW   = $clog2(NSRC + 1);
  localparam logic [VW-1:0] NONE = VW'(NSRC);

  logic [NSRC-1:0] route_q, en_q, type_q, pol_q, soft_q, latch_q, prev_q;
  logic [1:0]      mstr_q;
  logic [VW-1:0]   isv_irq_q, isv_fiq_q;

  logic [3:0] grp;
  logic [1:0] bk;
  logic       bank_ok;
  assign grp     = bus_addr[7:4];
  assign bk      = bus_addr[3:2];
  assign bank_ok = (int'(bk) < NUM_BANKS) && (bus_addr[1:0] == 2'b00);

  logic [NSRC+31:0] data_wide, ones_wide;
  assign data_wide = {{NSRC{1'b0}}, bus_wdata} << {bk, 5'b0};
  assign ones_wide = {{NSRC{1'b0}}, 32'hFFFF_FFFF} << {bk, 5'b0};

  logic [NSRC-1:0] wdat, wbank;
  assign wdat  = data_wide[NSRC-1:0];
  assign wbank = ones_wide[NSRC-1:0];

  function automatic logic [NSRC-1:0] hitmask(input logic [3:0] g);
    return (bus_wr && bank_ok && grp == g) ? wbank : '0;
  endfunction

  logic [NSRC-1:0] m_route, m_type, m_pol, m_soft, m_set, m_clr, m_lclr;
  assign m_route = hitmask(4'h0);
  assign m_clr   = hitmask(4'h2) & wdat;
  assign m_set   = hitmask(4'h3) & wdat;
  assign m_type  = hitmask(4'h4);
  assign m_pol   = hitmask(4'h5);
  assign m_lclr  = hitmask(4'hB) & wdat;
  assign m_soft  = hitmask(4'hC);

  logic [NSRC-1:0] adj, rise, pend, irq_st, fiq_st;
  assign adj    = src_i ^ pol_q;
  assign rise   = adj & ~prev_q & type_q;
  assign pend   = (type_q & latch_q) | (~type_q & adj) | soft_q;
  assign irq_st = pend & en_q & ~route_q;
  assign fiq_st = pend & en_q & route_q;

  function automatic logic [VW-1:0] pick(input logic [NSRC-1:0] v, input logic [VW-1:0] lim);
    logic [VW-1:0] r;
    r = NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i] && VW'(i) < lim) r = VW'(i);
    return r;
  endfunction

  logic [VW-1:0] irq_vec, fiq_vec;
  assign irq_vec = pick(irq_st, isv_irq_q);
  assign fiq_vec = pick(fiq_st, isv_fiq_q);
  assign irq_o   = mstr_q[0] && (irq_vec != NONE);
  assign fiq_o   = mstr_q[1] && (fiq_vec != NONE);

  logic ack_irq, ack_fiq, eoi_irq, eoi_fiq;
  assign ack_irq = bus_rd && (bus_addr == 8'hD0 || bus_addr == 8'hD4) && irq_vec != NONE;
  assign ack_fiq = bus_rd && (bus_addr == 8'hDC || bus_addr == 8'hE0) && fiq_vec != NONE;
  assign eoi_irq = bus_wr && bus_addr == 8'hD8;
  assign eoi_fiq = bus_wr && bus_addr == 8'hE4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q   <= '0;
      en_q      <= '0;
      type_q    <= '0;
      pol_q     <= '0;
      soft_q    <= '0;
      latch_q   <= '0;
      prev_q    <= '0;
      mstr_q    <= '0;
      isv_irq_q <= NONE;
      isv_fiq_q <= NONE;
    end else begin
      prev_q  <= adj;
      route_q <= (route_q & ~m_route) | (wdat & m_route);
      type_q  <= (type_q & ~m_type) | (wdat & m_type);
      pol_q   <= (pol_q & ~m_pol) | (wdat & m_pol);
      soft_q  <= (soft_q & ~m_soft) | (wdat & m_soft);
      en_q    <= (en_q & ~m_clr) | m_set;
      latch_q <= (latch_q & ~m_lclr) | rise;
      if (bus_wr && bus_addr == 8'h68) mstr_q <= bus_wdata[1:0];
      if (eoi_irq) isv_irq_q <= NONE;
      else if (ack_irq) isv_irq_q <= irq_vec;
      if (eoi_fiq) isv_fiq_q <= NONE;
      else if (ack_fiq) isv_fiq_q <= fiq_vec;
    end
  end

  logic [NSRC-1:0] rsel;
  always_comb begin
    rsel = '0;
    unique case (grp)
      4'h0: rsel = route_q;
      4'h1: rsel = en_q;
      4'h4: rsel = type_q;
      4'h5: rsel = pol_q;
      4'h8: rsel = irq_st;
      4'h9: rsel = fiq_st;
      4'hA: rsel = adj;
      4'hC: rsel = soft_q;
      default: rsel = '0;
    endcase
  end

  always_comb begin
    bus_rdata = bank_ok ? 32'(rsel >> {bk, 5'b0}) : 32'h0;
    case (bus_addr)
      8'h68:        bus_rdata = {30'h0, mstr_q};
      8'hD0, 8'hD4: bus_rdata = 32'(irq_vec);
      8'hDC, 8'hE0: bus_rdata = 32'(fiq_vec);
      8'hE8:        bus_rdata = 32'(isv_irq_q);
      8'hF0:        bus_rdata = 32'(isv_fiq_q);
      default: ;
    endcase
  end

  assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_set != '0) |=> ((en_q & $past(m_set)) == $past(m_set)));
  assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_clr != '0) |=> ((en_q & $past(m_clr)) == '0));
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((latch_q & $past(rise)) == $past(rise)));
  assert_fiq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mstr_q[1] |-> !fiq_o);
  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_irq && !eoi_irq) |=> (isv_irq_q == $past(irq_vec)));
  assert_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_irq |=> (isv_irq_q == NONE));
  assert_eoi_fiq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fiq |=> (isv_fiq_q == NONE));
endmodule

// File: tb/vic_dual_bank_test.sv
module vic_dual_bank_test;
  localparam int PERIOD = 10;
  localparam int NB = 2;

  logic        clk = 0, rst_n = 0;
  logic [63:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 0, rd = 0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, fiq;
  int applied = 0, bad = 0;

  vic_dual_bank #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ackreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL R11 watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v, e;
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R11 reset state and unmapped reads
    for (int a = 0; a < 64; a++) begin
      rreg(8'(a * 4), v);
      e = (a*4 == 'hD0 || a*4 == 'hD4 || a*4 == 'hDC || a*4 == 'hE0 ||
           a*4 == 'hE8 || a*4 == 'hF0) ? 32'd64 : 32'd0;
      chk("R11", v, e);
    end
    chk("R11 irq", {31'b0, irq}, 0);
    chk("R11 fiq", {31'b0, fiq}, 0);

    wreg(8'h68, 3);
    // R1 R2 R3 R4 R8: every source alone, level, normal route
    for (int n = 0; n < 64; n++) begin
      logic [7:0] bo;
      logic [31:0] bit_m;
      bo = 8'((n / 32) * 4);
      bit_m = 32'h1 << (n % 32);
      wreg(8'h30 + bo, bit_m);
      rreg(8'h10 + bo, v); chk("R2 enable set", v, bit_m);
      src[n] = 1;
      rreg(8'h80 + bo, v); chk("R1 R3 irq status", v, bit_m);
      rreg(8'hA0 + bo, v); chk("R4 raw", v, bit_m);
      rreg(8'hD0, v);      chk("R8 vector", v, n);
      chk("R8 irq out", {31'b0, irq}, 1);
      src[n] = 0;
      rreg(8'hD4, v);      chk("R4 level drop", v, 64);
      chk("R8 irq idle", {31'b0, irq}, 0);
      wreg(8'h20 + bo, bit_m);
      rreg(8'h10 + bo, v); chk("R2 enable clear", v, 0);
    end

    // R2 zero bits unaffected, enable register not writable
    wreg(8'h30, 32'h6);
    wreg(8'h20, 32'h2);
    rreg(8'h10, v); chk("R2 zeros kept", v, 32'h4);
    wreg(8'h10, 32'hFFFF_FFFF);
    rreg(8'h10, v); chk("R2 read-only", v, 32'h4);
    // R1 out-of-range bank ignored
    wreg(8'h08, 32'hFFFF_FFFF);
    rreg(8'h08, v); chk("R1 bank range", v, 0);
    rreg(8'h00, v); chk("R1 bank range", v, 0);

    // R8 priority over many pairs
    wreg(8'h30, 32'hFFFF_FFFF);
    wreg(8'h34, 32'hFFFF_FFFF);
    for (int i = 0; i < 63; i += 3)
      for (int j = i + 1; j < 64; j += 7) begin
        src = '0; src[i] = 1; src[j] = 1;
        rreg(8'hD0, v); chk("R8 priority", v, i);
      end
    src = '0;

    // R4 polarity on source 35
    wreg(8'h54, 32'h8);
    rreg(8'hA4, v); chk("R4 inverted raw", v, 32'h8);
    rreg(8'hD0, v); chk("R4 active-low", v, 35);
    src[35] = 1;
    rreg(8'hD0, v); chk("R4 active-low idle", v, 64);
    src[35] = 0;
    wreg(8'h54, 0);

    // R3 R7 fast route on source 5
    wreg(8'h00, 32'h20);
    src[5] = 1;
    rreg(8'h90, v); chk("R3 fiq status", v, 32'h20);
    rreg(8'h80, v); chk("R3 irq status", v, 0);
    rreg(8'hDC, v); chk("R3 fiq vector", v, 5);
    rreg(8'hD0, v); chk("R3 irq vector", v, 64);
    chk("R3 fiq out", {31'b0, fiq}, 1);
    chk("R3 irq out", {31'b0, irq}, 0);
    wreg(8'h68, 1);
    rreg(8'h90, v); chk("R7 status kept", v, 32'h20);
    chk("R7 fiq gated", {31'b0, fiq}, 0);
    wreg(8'h68, 2);
    chk("R7 fiq on", {31'b0, fiq}, 1);
    wreg(8'h68, 3);
    src[5] = 0;
    wreg(8'h00, 0);

    // R5 edge type on source 9
    wreg(8'h40, 32'h200);
    src[9] = 1; @(negedge clk); src[9] = 0;
    rreg(8'hD0, v); chk("R5 latched", v, 9);
    rreg(8'h80, v); chk("R5 status", v, 32'h200);
    wreg(8'hB0, 32'h200);
    rreg(8'hD0, v); chk("R5 cleared", v, 64);
    src[9] = 1; @(negedge clk);
    wreg(8'hB0, 32'h200);
    rreg(8'hD0, v); chk("R5 held no edge", v, 64);
    src[9] = 0; @(negedge clk); @(negedge clk);
    addr = 8'hB0; wdata = 32'h200; wr = 1; src[9] = 1;
    @(negedge clk); wr = 0;
    rreg(8'hD0, v); chk("R5 edge beats clear", v, 9);
    src[9] = 0;
    wreg(8'hB0, 32'h200);
    wreg(8'h40, 0);

    // R6 software trigger on source 32
    wreg(8'hC4, 32'h1);
    rreg(8'hC4, v); chk("R6 readback", v, 1);
    rreg(8'hD0, v); chk("R6 vector", v, 32);
    wreg(8'hC4, 0);
    rreg(8'hD0, v); chk("R6 released", v, 64);

    // R9 R10 in-service masking, normal route
    src[10] = 1; src[20] = 1;
    ackreg(8'hD0, v); chk("R9 ack value", v, 10);
    rreg(8'hE8, v); chk("R9 in service", v, 10);
    rreg(8'hD0, v); chk("R9 masked", v, 64);
    chk("R9 irq masked", {31'b0, irq}, 0);
    src[4] = 1;
    rreg(8'hD0, v); chk("R9 preempt", v, 4);
    chk("R9 preempt out", {31'b0, irq}, 1);
    src[4] = 0;
    wreg(8'hD8, 32'h0);
    rreg(8'hE8, v); chk("R10 idle", v, 64);
    rreg(8'hD0, v); chk("R10 resumed", v, 10);
    chk("R10 irq out", {31'b0, irq}, 1);
    src[10] = 0; src[20] = 0;

    // R9 R10 fast route on source 40
    wreg(8'h04, 32'h100);
    src[40] = 1;
    ackreg(8'hDC, v); chk("R9 fiq ack", v, 40);
    rreg(8'hF0, v); chk("R9 fiq in service", v, 40);
    chk("R9 fiq masked", {31'b0, fiq}, 0);
    wreg(8'hE4, 32'h5A);
    rreg(8'hF0, v); chk("R10 fiq idle", v, 64);
    chk("R10 fiq out", {31'b0, fiq}, 1);
    src[40] = 0;

    summary();
  end
endmodule